// File: doc/BRIEF.md
# CAN Error Status and State Tracker

This block holds the protocol error state of a CAN controller core and presents it as three CPU-visible registers: a status byte, a 16-bit error-counter word and a small control nibble. The protocol engine sends it the next transmit and receive error counts, single-cycle pulses for each good transmission and good reception, and an event carrying a last-error code. From these inputs the block derives the warning, passive and bus-off flags. It raises a status interrupt when something the CPU enabled has happened.

A CPU write port clears the sticky flags and can load the last-error-code field. Writing code 7 ("no event since the CPU last looked") rearms detection. The next bus event overwrites that code, so software can tell whether any event occurred.

Top module: `can_err_status`

## Requirements
- R1: After reset the status byte reads 0x07 (all flags 0, error code 7), the error-counter word reads 0x0000, the control byte reads 0x01 (init set) and irq is 0.
- R2: One cycle after a counter update, the error-counter word holds the transmit count in bits 7:0. Bits 14:8 hold the receive count, saturated to 127. Bit 15 is 1 when the receive count is 128 or more.
- R3: Status bit 6 (warning) is 1 exactly when either count is 96 or more. Status bit 5 (passive) is 1 exactly when either count is 128 or more.
- R4: An update whose transmit count is 256 or more sets status bit 7 (bus-off), stores 255 as the transmit count and sets control bit 0 (init). Bus-off stays set until the CPU writes the status byte with bit 7 at 0.
- R5: A transmit-OK pulse sets status bit 3 and a receive-OK pulse sets status bit 4. Both flags are sticky. A CPU status write clears a flag where the written bit is 0 and leaves it alone where the bit is 1. A pulse in the same cycle as a clearing write wins.
- R6: An error event loads status bits 2:0 with its code: 0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC. A CPU status write loads bits 2:0 from its data. An event in the same cycle as a write wins.
- R7: Once the CPU writes code 7, the field stays 7 through counter updates and OK pulses until the next error event.
- R8: With control bit 2 (status interrupt enable) set, a transmit-OK pulse, a receive-OK pulse or an error event with code 1 to 6 makes the interrupt pending from the next cycle. An event with code 0 does not.
- R9: With control bit 3 (error interrupt enable) set, any change of the warning, passive or bus-off flag, in either direction, makes the interrupt pending. The pending state appears two cycles after the counter update or the write that caused the change.
- R10: irq equals the pending state ANDed with control bit 1 (interrupt enable). Clearing that enable masks irq but keeps the pending state. Any CPU status write clears the pending state, unless a new cause arrives in the same cycle.
- R11: A control write stores data bits 3:0. Control bits 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_vld | input | 1 | Counter update strobe |
| tec_nxt | input | 9 | Next transmit error count (256 and above means bus-off) |
| rec_nxt | input | 8 | Next receive error count |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_ok | input | 1 | Successful reception pulse |
| lec_vld | input | 1 | Error-code event strobe |
| lec_code | input | 3 | Error code of the event |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | 0 selects control, 1 selects status |
| cpu_wdata | input | 8 | CPU write data |
| ctrl_reg | output | 8 | Control byte |
| status_reg | output | 8 | Status byte |
| errcnt_reg | output | 16 | Error-counter word |
| irq | output | 1 | Status interrupt |

## Verification
A stale copy of the flags inside the interrupt logic would show as a missing or extra irq exactly two cycles after a counter update that crosses 96, 128 or 256. The bench therefore checks irq both one and two cycles after each crossing, including updates that cross no threshold. A corrupted sticky flag or error code shows in the status byte on the cycle after the pulse or write. Same-cycle races between set and clear are checked there as well. A lost pending bit shows when irq fails to return after the interrupt enable is set again.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_IDLE  = 3'd7
    } lec_e;

    typedef struct packed {
        logic boff;
        logic warn;
        logic pass;
    } errflags_t;

    typedef struct packed {
        logic eie;
        logic sie;
        logic ie;
        logic init;
    } ctrl_t;

    localparam int unsigned ST_BOFF = 7;
    localparam int unsigned ST_WARN = 6;
    localparam int unsigned ST_PASS = 5;
    localparam int unsigned ST_RXOK = 4;
    localparam int unsigned ST_TXOK = 3;

    localparam ctrl_t CTRL_RST = '{eie: 1'b0, sie: 1'b0, ie: 1'b0, init: 1'b1};

    function automatic logic is_error_code(lec_e c);
        return (c != LEC_NONE) && (c != LEC_IDLE);
    endfunction

endpackage

// File: rtl/can_err_cnt.sv
module can_err_cnt
    import can_err_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_vld,
    input  logic [CNT_W:0]   tec_nxt,
    input  logic [CNT_W-1:0] rec_nxt,
    input  logic             boff_clr,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output errflags_t        flags,
    output logic             boff_set
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] WARN_V  = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASS_LIM);

    logic [CNT_W-1:0] tec_q, rec_q;
    logic             boff_q;

    assign boff_set = cnt_vld && tec_nxt[CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            tec_q  <= '0;
            rec_q  <= '0;
            boff_q <= 1'b0;
        end else begin
            if (cnt_vld) begin
                tec_q <= tec_nxt[CNT_W] ? CNT_MAX : tec_nxt[CNT_W-1:0];
                rec_q <= rec_nxt;
            end
            if (boff_set)
                boff_q <= 1'b1;
            else if (boff_clr)
                boff_q <= 1'b0;
        end
    end

    assign tec        = tec_q;
    assign rec        = rec_q;
    assign flags.boff = boff_q;
    assign flags.warn = (tec_q >= WARN_V) || (rec_q >= WARN_V);
    assign flags.pass = (tec_q >= PASS_V) || (rec_q >= PASS_V);

    // R3
    pass_warn_chk: assert property (@(posedge clk) disable iff (rst)
        flags.pass |-> flags.warn);
    // R4
    boff_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.boff) |-> $past(boff_set));
    // R2
    tec_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_vld && !tec_nxt[CNT_W]) |=> (tec == $past(tec_nxt[CNT_W-1:0])));
endmodule

// File: rtl/can_err_stat.sv
module can_err_stat
    import can_err_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_wr,
    input  logic [7:0] st_wdata,
    input  logic       tx_ok,
    input  logic       rx_ok,
    input  logic       lec_vld,
    input  lec_e       lec_code,
    output logic       txok,
    output logic       rxok,
    output lec_e       lec
);
    logic txok_q, rxok_q;
    lec_e lec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            txok_q <= 1'b0;
            rxok_q <= 1'b0;
            lec_q  <= LEC_IDLE;
        end else begin
            if (tx_ok)
                txok_q <= 1'b1;
            else if (st_wr && !st_wdata[ST_TXOK])
                txok_q <= 1'b0;
            if (rx_ok)
                rxok_q <= 1'b1;
            else if (st_wr && !st_wdata[ST_RXOK])
                rxok_q <= 1'b0;
            if (lec_vld)
                lec_q <= lec_code;
            else if (st_wr)
                lec_q <= lec_e'(st_wdata[2:0]);
        end
    end

    assign txok = txok_q;
    assign rxok = rxok_q;
    assign lec  = lec_q;

    // R5
    txok_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txok && !(st_wr && !st_wdata[ST_TXOK])) |=> txok);
    // R7
    lec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!lec_vld && !st_wr) |=> $stable(lec));
endmodule

// File: rtl/can_err_irq.sv
module can_err_irq
    import can_err_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctrl_t     ctrl,
    input  errflags_t flags,
    input  logic      tx_ok,
    input  logic      rx_ok,
    input  logic      lec_vld,
    input  lec_e      lec_code,
    input  logic      st_wr,
    output logic      irq
);
    errflags_t prev_q;
    logic      pend_q;
    logic      err_cause, stat_cause;

    assign err_cause  = ctrl.eie && (flags != prev_q);
    assign stat_cause = ctrl.sie && (tx_ok || rx_ok ||
                                     (lec_vld && is_error_code(lec_code)));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= flags;
            if (err_cause || stat_cause)
                pend_q <= 1'b1;
            else if (st_wr)
                pend_q <= 1'b0;
        end
    end

    assign irq = pend_q && ctrl.ie;

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !st_wr) |=> pend_q);
    // R8
    stat_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sie && (tx_ok || rx_ok)) |=> pend_q);
endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import can_err_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_vld,
    input  logic [CNT_W:0]     tec_nxt,
    input  logic [CNT_W-1:0]   rec_nxt,
    input  logic               tx_ok,
    input  logic               rx_ok,
    input  logic               lec_vld,
    input  logic [2:0]         lec_code,
    input  logic               cpu_we,
    input  logic               cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         ctrl_reg,
    output logic [7:0]         status_reg,
    output logic [2*CNT_W-1:0] errcnt_reg,
    output logic               irq
);
    localparam logic [CNT_W-2:0] REC_SAT = '1;

    logic             st_wr, ct_wr, boff_set;
    logic [CNT_W-1:0] tec, rec;
    errflags_t        flags;
    ctrl_t            ctrl_q;
    logic             txok, rxok;
    lec_e             lec, lec_in;

    assign st_wr  = cpu_we && cpu_addr;
    assign ct_wr  = cpu_we && !cpu_addr;
    assign lec_in = lec_e'(lec_code);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else begin
            if (ct_wr)
                ctrl_q <= ctrl_t'(cpu_wdata[3:0]);
            if (boff_set)
                ctrl_q.init <= 1'b1;
        end
    end

    can_err_cnt #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_vld  (cnt_vld),
        .tec_nxt  (tec_nxt),
        .rec_nxt  (rec_nxt),
        .boff_clr (st_wr && !cpu_wdata[ST_BOFF]),
        .tec      (tec),
        .rec      (rec),
        .flags    (flags),
        .boff_set (boff_set)
    );

    can_err_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .st_wr    (st_wr),
        .st_wdata (cpu_wdata),
        .tx_ok    (tx_ok),
        .rx_ok    (rx_ok),
        .lec_vld  (lec_vld),
        .lec_code (lec_in),
        .txok     (txok),
        .rxok     (rxok),
        .lec      (lec)
    );

    can_err_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .flags    (flags),
        .tx_ok    (tx_ok),
        .rx_ok    (rx_ok),
        .lec_vld  (lec_vld),
        .lec_code (lec_in),
        .st_wr    (st_wr),
        .irq      (irq)
    );

    assign ctrl_reg   = {4'b0000, ctrl_q};
    assign status_reg = {flags.boff, flags.warn, flags.pass, rxok, txok, lec};
    assign errcnt_reg = {rec[CNT_W-1], (rec[CNT_W-1] ? REC_SAT : rec[CNT_W-2:0]), tec};

    // R4
    boff_init_chk: assert property (@(posedge clk) disable iff (rst)
        boff_set |=> ctrl_reg[0]);
endmodule

// File: tb/can_err_status_tb.sv
module can_err_status_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_vld = 1'b0;
    logic [8:0]  tec_nxt = '0;
    logic [7:0]  rec_nxt = '0;
    logic        tx_ok = 1'b0, rx_ok = 1'b0, lec_vld = 1'b0;
    logic [2:0]  lec_code = '0;
    logic        cpu_we = 1'b0, cpu_addr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  ctrl_reg, status_reg;
    logic [15:0] errcnt_reg;
    logic        irq;
    int          checks = 0;
    int          failures = 0;

    always #2 clk = ~clk;

    can_err_status u_dut (
        .clk(clk), .rst(rst), .cnt_vld(cnt_vld), .tec_nxt(tec_nxt), .rec_nxt(rec_nxt),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .lec_vld(lec_vld), .lec_code(lec_code),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .ctrl_reg(ctrl_reg), .status_reg(status_reg), .errcnt_reg(errcnt_reg), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(logic a, logic [7:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_we = 1'b0;
    endtask

    task automatic cnt_upd(logic [8:0] t, logic [7:0] r);
        cnt_vld = 1'b1; tec_nxt = t; rec_nxt = r;
        tick();
        cnt_vld = 1'b0;
    endtask

    task automatic lec_evt(logic [2:0] c);
        lec_vld = 1'b1; lec_code = c;
        tick();
        lec_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "status", 16'(status_reg), 16'h07);
        chk("R1", "errcnt", errcnt_reg, 16'h0000);
        chk("R1", "ctrl", 16'(ctrl_reg), 16'h01);
        chk("R1", "irq", 16'(irq), 16'h0);
    endtask

    task automatic t_ctrl();
        cpu_write(1'b0, 8'hFE);
        chk("R11", "ctrl upper bits", 16'(ctrl_reg), 16'h0E);
    endtask

    task automatic t_counts();
        cnt_upd(9'd50, 8'd20);
        chk("R2", "errcnt 50/20", errcnt_reg, 16'h1432);
        chk("R3", "status no flags", 16'(status_reg), 16'h07);
        tick();
        chk("R9", "no change no irq", 16'(irq), 16'h0);
        cnt_upd(9'd10, 8'd200);
        chk("R2", "errcnt rec saturated", errcnt_reg, 16'hFF0A);
        chk("R3", "warn+passive from rec", 16'(status_reg), 16'h67);
        chk("R9", "irq not yet", 16'(irq), 16'h0);
        tick();
        chk("R9", "irq after flag change", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h07);
        chk("R10", "write clears pending", 16'(irq), 16'h0);
        chk("R3", "flags read-only", 16'(status_reg), 16'h67);
        cnt_upd(9'd95, 8'd0);
        chk("R3", "tec 95", 16'(status_reg), 16'h07);
        tick();
        chk("R9", "flags fell irq", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h07);
        cnt_upd(9'd96, 8'd0);
        chk("R3", "tec 96", 16'(status_reg), 16'h47);
        tick(); cpu_write(1'b1, 8'h07);
        cnt_upd(9'd127, 8'd0);
        chk("R3", "tec 127", 16'(status_reg), 16'h47);
        tick();
        chk("R9", "no crossing no irq", 16'(irq), 16'h0);
        cnt_upd(9'd128, 8'd0);
        chk("R3", "tec 128", 16'(status_reg), 16'h67);
        tick(); cpu_write(1'b1, 8'h07);
        cnt_upd(9'd0, 8'd95);
        chk("R3", "rec 95", 16'(status_reg), 16'h07);
        tick(); cpu_write(1'b1, 8'h07);
        cnt_upd(9'd0, 8'd96);
        chk("R3", "rec 96", 16'(status_reg), 16'h47);
        chk("R2", "errcnt rec 96", errcnt_reg, 16'h6000);
        tick(); cpu_write(1'b1, 8'h07);
    endtask

    task automatic t_boff();
        cnt_upd(9'd300, 8'd0);
        chk("R4", "status bus-off", 16'(status_reg), 16'hE7);
        chk("R4", "tec held 255", errcnt_reg, 16'h00FF);
        chk("R4", "init set", 16'(ctrl_reg), 16'h0F);
        tick();
        chk("R9", "irq bus-off", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h87);
        chk("R4", "bit7=1 keeps bus-off", 16'(status_reg), 16'hE7);
        cpu_write(1'b1, 8'h07);
        chk("R4", "bit7=0 clears bus-off", 16'(status_reg), 16'h67);
        tick();
        chk("R9", "bus-off exit irq", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h07);
        cpu_write(1'b0, 8'h0E);
        cnt_upd(9'd0, 8'd0);
        tick(); cpu_write(1'b1, 8'h07);
        chk("R3", "counters back to 0", 16'(status_reg), 16'h07);
    endtask

    task automatic t_okflags();
        tx_ok = 1'b1; tick(); tx_ok = 1'b0;
        chk("R5", "txok set", 16'(status_reg), 16'h0F);
        chk("R8", "txok irq", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h0F);
        chk("R5", "write 1 keeps txok", 16'(status_reg), 16'h0F);
        rx_ok = 1'b1; tick(); rx_ok = 1'b0;
        chk("R5", "rxok set", 16'(status_reg), 16'h1F);
        chk("R8", "rxok irq", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h17);
        chk("R5", "txok cleared", 16'(status_reg), 16'h17);
        tx_ok = 1'b1;
        cpu_write(1'b1, 8'h07);
        tx_ok = 1'b0;
        chk("R5", "pulse beats clear", 16'(status_reg), 16'h0F);
        chk("R10", "new cause beats clear", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h07);
        chk("R5", "all ok flags cleared", 16'(status_reg), 16'h07);
    endtask

    task automatic t_lec();
        cpu_write(1'b1, 8'h00);
        chk("R6", "cpu loads code 0", 16'(status_reg), 16'h00);
        for (int c = 1; c <= 6; c++) begin
            lec_evt(3'(c));
            chk("R6", "event code", 16'(status_reg), 16'(c));
            chk("R8", "error code irq", 16'(irq), 16'h1);
        end
        cpu_write(1'b1, 8'h07);
        chk("R7", "rearm to 7", 16'(status_reg), 16'h07);
        chk("R10", "irq cleared", 16'(irq), 16'h0);
        cnt_upd(9'd10, 8'd10);
        tick();
        chk("R7", "counter update keeps 7", 16'(status_reg), 16'h07);
        tx_ok = 1'b1; tick(); tx_ok = 1'b0;
        chk("R7", "txok keeps 7", 16'(status_reg), 16'h0F);
        cpu_write(1'b1, 8'h07);
        lec_evt(3'd0);
        chk("R6", "code 0 overwrites 7", 16'(status_reg), 16'h00);
        chk("R8", "code 0 no irq", 16'(irq), 16'h0);
        lec_vld = 1'b1; lec_code = 3'd5;
        cpu_write(1'b1, 8'h07);
        lec_vld = 1'b0;
        chk("R6", "event beats write", 16'(status_reg), 16'h05);
        cpu_write(1'b1, 8'h07);
    endtask

    task automatic t_mask();
        cpu_write(1'b0, 8'h0C);
        tx_ok = 1'b1; tick(); tx_ok = 1'b0;
        chk("R10", "ie=0 masks irq", 16'(irq), 16'h0);
        cpu_write(1'b0, 8'h0E);
        chk("R10", "pending kept while masked", 16'(irq), 16'h1);
        cpu_write(1'b1, 8'h07);
        cpu_write(1'b0, 8'h0A);
        rx_ok = 1'b1; tick(); rx_ok = 1'b0;
        tick();
        chk("R8", "sie=0 no irq", 16'(irq), 16'h0);
        cpu_write(1'b0, 8'h06);
        cnt_upd(9'd100, 8'd0);
        chk("R3", "warn with rxok", 16'(status_reg), 16'h57);
        tick(); tick();
        chk("R9", "eie=0 no irq", 16'(irq), 16'h0);
        cpu_write(1'b0, 8'h0E);
        chk("R9", "nothing latched", 16'(irq), 16'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_counts();
        t_boff();
        t_okflags();
        t_lec();
        t_mask();
        finish_run();
    end
endmodule